// File: doc/BRIEF.md
# Selectable Reference Frequency Divider

This block turns a reference clock into a comparison-rate pulse for a frequency synthesiser loop. It works in two stages. A fixed first stage divides by one hundred. A second stage then divides that result by 1, 2, 4, 5, 8, 10, 16 or 20, as chosen by a 3-bit select code that has already been latched. The comparison output is a strobe one reference cycle wide, issued once per full division period. A delayed copy of the strobe is also provided, and a monitor square wave at one hundredth of the reference helps when trimming the crystal.

The select code is read only at the start of a comparison period. A change made partway through a period therefore takes effect when the period ends, and no shortened period can occur. Reset clears every counter. The first strobe arrives exactly one full period after reset is released.

Top module: `ref_divider`

## Requirements
- R1: While `rst_n` is low, `cmp_pulse`, `cmp_q` and `mon_out` are 0 and both counter stages are cleared.
- R2: The strobe period in reference cycles is 100 times the post ratio. Codes 3'b000 to 3'b111 select post ratios 16, 8, 4, 2, 20, 10, 5 and 1, which gives totals of 1600, 800, 400, 200, 2000, 1000, 500 and 100.
- R3: `cmp_pulse` is high for exactly one reference cycle per period.
- R4: After reset is released, the first `cmp_pulse` is high following clock edge P, where P is the full period of the selected code. Edges are counted from 1 at the first edge with `rst_n` high.
- R5: `sel` is sampled on the first edge of each period, that is the first edge after reset release and the edge that follows each strobe edge. A change at any other time has no effect until the next period.
- R6: `mon_out` is a square wave with a period of 100 reference cycles and 50% duty. It rises after edge 50 following reset release and toggles every 50 edges after that.
- R7: `cmp_q` equals `cmp_pulse` delayed by one reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Latched ratio select code |
| cmp_pulse | output | 1 | One-cycle comparison strobe |
| mon_out | output | 1 | Reference divided by 100, square wave |
| cmp_q | output | 1 | Strobe registered one more cycle |

## Verification
A registered strobe is due on the edge that completes 100×ratio cycles. The monitor output changes on every 50th edge, and the delayed copy follows one edge after the strobe. A behavioural model in the bench counts edges from reset release and samples `sel` only when a new period opens. The model and the DUT both update on the rising edge, and the bench compares all three outputs at the following falling edge, so every expected value is read in the cycle it is due. Select changes made in mid-period confirm that the old length is still used for that period, and a separate count of edges from a second reset release confirms the latency of the first strobe.

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int PRE_DIV = 100
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       cmp_pulse,
  output logic       mon_out,
  output logic       cmp_q
);
  localparam int PW   = $clog2(PRE_DIV);
  localparam int HALF = PRE_DIV / 2;
  localparam int QW   = 5;

  function automatic logic [QW-1:0] post_ratio(input logic [2:0] c);
    case (c)
      3'd0: post_ratio = QW'(16);
      3'd1: post_ratio = QW'(8);
      3'd2: post_ratio = QW'(4);
      3'd3: post_ratio = QW'(2);
      3'd4: post_ratio = QW'(20);
      3'd5: post_ratio = QW'(10);
      3'd6: post_ratio = QW'(5);
      default: post_ratio = QW'(1);
    endcase
  endfunction

  logic [PW-1:0] pre_cnt;
  logic [QW-1:0] post_cnt;
  logic [2:0]    act_code;

  wire pre_tick  = pre_cnt == PW'(PRE_DIV - 1);
  wire mon_flip  = pre_tick || (pre_cnt == PW'(HALF - 1));
  wire opening   = (pre_cnt == '0) && (post_cnt == '0);
  wire post_last = post_cnt == QW'(post_ratio(act_code) - QW'(1));
  wire wrap      = pre_tick && post_last;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      post_cnt  <= '0;
      act_code  <= '0;
      cmp_pulse <= 1'b0;
      cmp_q     <= 1'b0;
      mon_out   <= 1'b0;
    end else begin
      pre_cnt   <= pre_tick ? '0 : pre_cnt + PW'(1);
      if (pre_tick) post_cnt <= post_last ? '0 : post_cnt + QW'(1);
      if (opening) act_code <= sel;
      cmp_pulse <= wrap;
      cmp_q     <= cmp_pulse;
      if (mon_flip) mon_out <= ~mon_out;
    end
  end
endmodule

module ref_divider_chk #(
  parameter int PW = 7,
  parameter int QW = 5
) (
  input logic          clk_ref,
  input logic          rst_n,
  input logic          cmp_pulse,
  input logic          cmp_q,
  input logic          mon_out,
  input logic [PW-1:0] pre_cnt,
  input logic [QW-1:0] post_cnt,
  input logic [2:0]    act_code
);
  always @(posedge clk_ref)
    if (!rst_n) assert_reset_quiet_R1: assert (!cmp_pulse && !cmp_q && !mon_out && pre_cnt == '0 && post_cnt == '0);

  assert_strobe_on_boundary_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_pulse |-> (pre_cnt == '0));
  assert_single_cycle_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_pulse && (post_cnt != '0 || act_code != 3'd7) |=> !cmp_pulse);
  assert_code_held_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pre_cnt != '0 || post_cnt != '0) |=> $stable(act_code));
  assert_mon_steady_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pre_cnt != PW'(49) && pre_cnt != PW'(99)) |=> $stable(mon_out));
  assert_delay_high_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_pulse |=> cmp_q);
  assert_delay_low_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cmp_pulse |=> !cmp_q);
endmodule

bind ref_divider ref_divider_chk #(.PW(PW), .QW(QW)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .cmp_pulse(cmp_pulse), .cmp_q(cmp_q),
  .mon_out(mon_out), .pre_cnt(pre_cnt), .post_cnt(post_cnt), .act_code(act_code)
);

// File: tb/ref_divider_tb.sv
module ref_divider_tb;
  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic cmp_pulse, mon_out, cmp_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ref_divider u_dut (.clk_ref(clk_ref), .rst_n(rst_n), .sel(sel),
                     .cmp_pulse(cmp_pulse), .mon_out(mon_out), .cmp_q(cmp_q));

  always #10 clk_ref = ~clk_ref;

  function automatic int total_of(input logic [2:0] c);
    int t [8] = '{1600, 800, 400, 200, 2000, 1000, 500, 100};
    return t[c];
  endfunction

  int m_pos = 0, m_per = 0, m_edges = 0;
  bit m_pulse = 0, m_q = 0, m_mon = 0;

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_per = 0; m_edges = 0; m_pulse = 0; m_q = 0; m_mon = 0;
    end else begin
      m_edges++;
      m_q = m_pulse;
      if (m_pos == 0) m_per = total_of(sel);
      m_pos++;
      if (m_pos == m_per) begin m_pulse = 1; m_pos = 0; end
      else m_pulse = 0;
      m_mon = ((m_edges / 50) % 2) == 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk_ref) begin
    if (!rst_n) begin
      check("R1 pulse in reset", cmp_pulse, 1'b0);
      check("R1 q in reset", cmp_q, 1'b0);
      check("R1 mon in reset", mon_out, 1'b0);
    end else begin
      check("R2 R3 R5 strobe", cmp_pulse, m_pulse);
      check("R6 monitor", mon_out, m_mon);
      check("R7 delayed copy", cmp_q, m_q);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  initial begin
    run(5);
    @(negedge clk_ref) rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      sel = 3'(c);
      run(2 * total_of(3'(c)) + 150);
    end
    sel = 3'd7;
    run(250);
    sel = 3'd3;
    run(30);
    sel = 3'd7;
    run(30);
    sel = 3'd1;
    run(1800);
    sel = 3'd6;
    run(900);
    rst_n = 1'b0;
    run(4);
    sel = 3'd4;
    @(negedge clk_ref) rst_n = 1'b1;
    begin : first_strobe_r4
      int k = 0;
      while (k < 2100) begin
        @(negedge clk_ref);
        k++;
        if (cmp_pulse) break;
      end
      n_chk++;
      if (k != 2000) begin
        n_bad++;
        $display("FAIL R4 first strobe edge: actual %0d expected %0d", k, 2000);
      end
    end
    run(300);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_ref);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule